// File: doc/BRIEF.md
# Host Data Start Alignment Extractor

This block sits on the host data path of a 2D drawing engine. During a transfer the host pushes 32-bit words into the engine. The block picks out the data units the operation actually uses: single bits for monochrome host-to-screen transfers, 4-bit nibbles or 8-bit bytes for alpha-expand transfers, and bytes for ordinary transfers. A later stage turns these units into pixels.

The low bits of the linear source address register set where the first valid unit sits. In the mono, nibble and alpha-byte modes these bits index into the host data stream, not into memory. When the index points past the first word, whole leading words are discarded. Only units ahead of the start point in the first data of an operation are dropped; every unit after that is passed on in order.

Software loads the register. `start_i` begins an operation with a unit count. The operation ends when that many units have been delivered. Any units left over in the last word are thrown away.

Top module: `host_unit_extractor`

## Requirements
- R1: The address register holds 23 bits (22:0) and resets to zero. A write stores bits 22:0, and read-back bits 31:23 are always zero.
- R2: The register changes only on a write strobe. Running operations never alter it.
- R3: Mono mode (`mode_i`=1). The first bit is selected by address bits 4:0. Bits 4:3 pick the byte and bits 2:0 pick the bit within it, where bit index 0 is the byte's MSB. Each unit appears on `unit_o[0]`, and `unit_o[7:1]` is zero.
- R4: Nibble mode (`mode_i`=2). Address bits 2:0 select the first nibble of the word, and address bit 3 set means one whole host word is skipped first. Each unit appears on `unit_o[3:0]`, and `unit_o[7:4]` is zero.
- R5: Alpha-byte mode (`mode_i`=3). Address bits 1:0 select the first byte, and address bit 2 set means one whole host word is skipped first.
- R6: Plain byte mode (`mode_i`=0). Address bits 1:0 select the first byte, and no words are skipped.
- R7: Within a word, bytes are emitted from bits 7:0 upward. Within a byte, bits and nibbles are emitted MSB first.
- R8: The skip applies only to the first data of an operation. Every later word delivers all of its units, starting at position 0.
- R9: An operation emits exactly `unit_cnt_i` units. `unit_last_o` is high on the final unit only. After that unit no more host words are accepted, and leftover units are dropped.
- R10: `start_i` abandons any operation in progress and starts a fresh one from the current register value. A count of zero produces no units and accepts no words.
- R11: While `unit_valid_o` is high and `unit_ready_i` is low, the unit and its last flag stay stable. `host_ready_o` is low whenever a word is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 32 | Address register write data |
| addr_o | output | 32 | Address register read-back |
| mode_i | input | 2 | Unpack mode, sampled on start: 0 byte, 1 mono, 2 nibble, 3 alpha byte |
| start_i | input | 1 | Begin a new operation |
| unit_cnt_i | input | 16 | Units to deliver, sampled on start |
| host_data_i | input | 32 | Host data word |
| host_valid_i | input | 1 | Host word valid |
| host_ready_o | output | 1 | Block accepts a host word |
| unit_o | output | 8 | Extracted unit, right-aligned |
| unit_valid_o | output | 1 | Unit valid |
| unit_ready_i | input | 1 | Downstream accepts the unit |
| unit_last_o | output | 1 | Final unit of the operation |

## Verification
The assertions check, on every cycle, that:
- the register holds its value when no write strobe is present;
- units stay stable under backpressure;
- unused upper unit bits are zero in mono and nibble modes;
- no unit is presented while a word skip is pending;
- the stream closes after the last unit.

Only the bench scenarios can show the behaviours that depend on the data itself:
- which bit, nibble or byte comes out first for a given address;
- the order of units across word boundaries;
- the number of host words consumed;
- correct restart in the middle of an operation.

// File: rtl/hue_pkg.sv
package hue_pkg;
  typedef enum logic [1:0] {
    MODE_BYTE   = 2'd0,
    MODE_MONO   = 2'd1,
    MODE_NIB    = 2'd2,
    MODE_ALPHA8 = 2'd3
  } hue_mode_e;
endpackage

// File: rtl/hue_addr_reg.sv
module hue_addr_reg #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (we_i) addr_q <= wdata_i[ADDR_W-1:0];
  end

  assign addr_o = REG_W'(addr_q);

  assert_reg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(addr_o));
endmodule

// File: rtl/hue_start_decode.sv
module hue_start_decode
  import hue_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  hue_mode_e        mode_i,
  input  logic [POS_W-1:0] addr_i,
  output logic [POS_W-1:0] first_pos_o,
  output logic [POS_W-1:0] last_pos_o,
  output logic             skip_o
);
  // bits above the in-word index ask for one whole leading word to be skipped
  always_comb begin
    unique case (mode_i)
      MODE_MONO: begin
        first_pos_o = addr_i;
        last_pos_o  = POS_W'(WORD_W - 1);
        skip_o      = 1'b0;
      end
      MODE_NIB: begin
        first_pos_o = POS_W'(addr_i[POS_W-3:0]);
        last_pos_o  = POS_W'(WORD_W/4 - 1);
        skip_o      = addr_i[POS_W-2];
      end
      MODE_ALPHA8: begin
        first_pos_o = POS_W'(addr_i[POS_W-4:0]);
        last_pos_o  = POS_W'(WORD_W/8 - 1);
        skip_o      = addr_i[POS_W-3];
      end
      default: begin
        first_pos_o = POS_W'(addr_i[POS_W-4:0]);
        last_pos_o  = POS_W'(WORD_W/8 - 1);
        skip_o      = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hue_unit_select.sv
module hue_unit_select
  import hue_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int UNIT_W = 8,
  localparam int POS_W  = $clog2(WORD_W),
  localparam int BYTES  = WORD_W / 8,
  localparam int BIDX_W = $clog2(BYTES)
) (
  input  logic [WORD_W-1:0] word_i,
  input  hue_mode_e         mode_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [UNIT_W-1:0] unit_o
);
  logic [BIDX_W-1:0] bidx;
  logic [7:0]        byte_v;

  always_comb begin
    unique case (mode_i)
      MODE_MONO: bidx = pos_i[BIDX_W+2:3];
      MODE_NIB:  bidx = pos_i[BIDX_W:1];
      default:   bidx = pos_i[BIDX_W-1:0];
    endcase
  end

  // lowest address byte sits in bits 7:0
  always_comb begin
    byte_v = '0;
    for (int b = 0; b < BYTES; b++)
      if (BIDX_W'(b) == bidx) byte_v = word_i[b*8 +: 8];
  end

  // MSB-first inside a byte
  always_comb begin
    unique case (mode_i)
      MODE_MONO: unit_o = UNIT_W'(byte_v[3'd7 - pos_i[2:0]]);
      MODE_NIB:  unit_o = UNIT_W'(pos_i[0] ? byte_v[3:0] : byte_v[7:4]);
      default:   unit_o = UNIT_W'(byte_v);
    endcase
  end
endmodule

// File: rtl/host_unit_extractor.sv
module host_unit_extractor
  import hue_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 23,
  parameter int WORD_W = 32,
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [REG_W-1:0]  addr_wdata_i,
  output logic [REG_W-1:0]  addr_o,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  unit_cnt_i,
  input  logic [WORD_W-1:0] host_data_i,
  input  logic              host_valid_i,
  output logic              host_ready_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              unit_valid_o,
  input  logic              unit_ready_i,
  output logic              unit_last_o
);
  localparam int POS_W = $clog2(WORD_W);

  logic [POS_W-1:0]  first_pos, last_pos;
  logic              skip_dec;

  hue_mode_e         mode_q;
  logic [WORD_W-1:0] word_q;
  logic [POS_W-1:0]  pos_q, last_pos_q;
  logic [CNT_W-1:0]  remain_q;
  logic              skip_q, active_q, full_q;
  logic              host_fire, unit_fire;

  hue_addr_reg #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_addr_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (addr_we_i),
    .wdata_i (addr_wdata_i),
    .addr_o  (addr_o)
  );

  hue_start_decode #(.WORD_W(WORD_W)) i_start_decode (
    .mode_i      (hue_mode_e'(mode_i)),
    .addr_i      (addr_o[POS_W-1:0]),
    .first_pos_o (first_pos),
    .last_pos_o  (last_pos),
    .skip_o      (skip_dec)
  );

  hue_unit_select #(.WORD_W(WORD_W), .UNIT_W(UNIT_W)) i_unit_select (
    .word_i (word_q),
    .mode_i (mode_q),
    .pos_i  (pos_q),
    .unit_o (unit_o)
  );

  assign host_ready_o = active_q && !full_q;
  assign unit_valid_o = full_q;
  assign unit_last_o  = full_q && (remain_q == CNT_W'(1));
  assign host_fire    = host_ready_o && host_valid_i;
  assign unit_fire    = unit_valid_o && unit_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_BYTE;
      word_q     <= '0;
      pos_q      <= '0;
      last_pos_q <= '0;
      remain_q   <= '0;
      skip_q     <= 1'b0;
      active_q   <= 1'b0;
      full_q     <= 1'b0;
    end else if (start_i) begin
      mode_q     <= hue_mode_e'(mode_i);
      pos_q      <= first_pos;
      last_pos_q <= last_pos;
      skip_q     <= skip_dec;
      remain_q   <= unit_cnt_i;
      active_q   <= (unit_cnt_i != '0);
      full_q     <= 1'b0;
    end else begin
      if (host_fire) begin
        if (skip_q) skip_q <= 1'b0;  // discard a whole leading word
        else begin
          word_q <= host_data_i;
          full_q <= 1'b1;
        end
      end
      if (unit_fire) begin
        remain_q <= remain_q - CNT_W'(1);
        if (remain_q == CNT_W'(1)) begin
          full_q   <= 1'b0;
          active_q <= 1'b0;
        end else if (pos_q == last_pos_q) begin
          full_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end

  assert_unit_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_valid_o && !unit_ready_i && !start_i |=>
      unit_valid_o && $stable(unit_o) && $stable(unit_last_o));

  assert_end_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_fire && unit_last_o && !start_i |=> !unit_valid_o && !host_ready_o);

  assert_mono_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_valid_o && mode_q == MODE_MONO |-> unit_o[UNIT_W-1:1] == '0);

  assert_nib_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_valid_o && mode_q == MODE_NIB |-> unit_o[UNIT_W-1:4] == '0);

  assert_skip_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> !unit_valid_o);
endmodule

// File: tb/test_host_unit_extractor.sv
`timescale 1ns/1ps
module test_host_unit_extractor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_we;
  logic [31:0] addr_wdata, addr_rd;
  logic [1:0]  mode;
  logic        start;
  logic [15:0] cnt;
  logic [31:0] host_data;
  logic        host_valid, host_ready;
  logic [7:0]  unit;
  logic        unit_valid, unit_ready, unit_last;

  int checks = 0, fails = 0;
  int widx = 0, ngot = 0, cyc = 0;
  logic [7:0] got [64];
  logic       gotlast [64];
  logic       bp = 1'b0, hold = 1'b0;

  always #2 clk = ~clk;

  host_unit_extractor i_host_unit_extractor (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(addr_we), .addr_wdata_i(addr_wdata),
    .addr_o(addr_rd), .mode_i(mode), .start_i(start), .unit_cnt_i(cnt),
    .host_data_i(host_data), .host_valid_i(host_valid), .host_ready_o(host_ready),
    .unit_o(unit), .unit_valid_o(unit_valid), .unit_ready_i(unit_ready),
    .unit_last_o(unit_last)
  );

  function automatic logic [31:0] gen(int w);
    return 32'hC3A5_5A3C ^ (w * 32'h0101_1011) ^ (w << 7);
  endfunction

  // reference: unit k of an operation from the requirements
  function automatic logic [7:0] ref_unit(int m, int a, int k);
    int mask, u, g, p;
    logic [31:0] wd;
    logic [7:0] b;
    case (m)
      1: begin mask = 31; u = 32; end
      2: begin mask = 15; u = 8;  end
      3: begin mask = 7;  u = 4;  end
      default: begin mask = 3; u = 4; end
    endcase
    g  = (a & mask) + k;
    wd = gen(g / u);
    p  = g % u;
    case (m)
      1: begin b = wd[(p/8)*8 +: 8]; return {7'b0, b[7-(p%8)]}; end
      2: begin b = wd[(p/2)*8 +: 8]; return (p%2 == 0) ? {4'b0, b[7:4]} : {4'b0, b[3:0]}; end
      default: return wd[p*8 +: 8];
    endcase
  endfunction

  assign host_data  = gen(widx);
  assign unit_ready = !start && !hold && (!bp || (cyc % 3 != 0));

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (host_valid && host_ready) widx <= widx + 1;
    if (unit_valid && unit_ready && ngot < 64) begin
      got[ngot]     <= unit;
      gotlast[ngot] <= unit_last;
      ngot          <= ngot + 1;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_addr(logic [31:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic begin_op(int m, int c);
    @(negedge clk);
    host_valid = 1'b0; ngot = 0; widx = 0;
    start = 1'b1; mode = 2'(m); cnt = 16'(c);
    @(negedge clk);
    start = 1'b0; host_valid = 1'b1;
  endtask

  task automatic wait_units(int c);
    for (int t = 0; t < 400 && ngot < c; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  localparam int NV = 10;
  localparam int V_MODE  [NV] = '{1, 1, 1, 2, 2, 3, 3, 0, 2, 3};
  localparam int V_ADDR  [NV] = '{'h13, 'hFF7F_FFE0, 'h1F, 'h5, 'hB, 'h6, 'h1, 'h3, 'h8, 'h4};
  localparam int V_CNT   [NV] = '{20, 32, 3, 6, 4, 5, 3, 6, 8, 1};
  localparam int V_WORDS [NV] = '{2, 1, 2, 2, 2, 3, 1, 3, 2, 2};

  function automatic string mode_req(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; addr_we = 1'b0; addr_wdata = '0; mode = '0;
    start = 1'b0; cnt = '0; host_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!host_ready && !unit_valid, "R1", "reset outputs idle", {host_ready, unit_valid}, 0);
    check(addr_rd == 32'h0, "R1", "reset address", addr_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] exp_addr;
      bp = v[0];
      write_addr(32'(V_ADDR[v]));
      exp_addr = 32'(V_ADDR[v]) & 32'h007F_FFFF;
      check(addr_rd == exp_addr, "R1", "address read-back", addr_rd, exp_addr);
      begin_op(V_MODE[v], V_CNT[v]);
      wait_units(V_CNT[v]);
      host_valid = 1'b0;
      check(ngot == V_CNT[v], "R9", "unit count", ngot, V_CNT[v]);
      // R7 ordering is implied by the reference
      for (int k = 0; k < V_CNT[v] && k < ngot; k++) begin
        logic [7:0] e;
        e = ref_unit(V_MODE[v], V_ADDR[v], k);
        check(got[k] == e, mode_req(V_MODE[v]), $sformatf("vec %0d unit %0d", v, k), got[k], e);
        check(gotlast[k] == (k == V_CNT[v]-1), "R9", $sformatf("vec %0d last %0d", v, k),
              gotlast[k], k == V_CNT[v]-1);
      end
      check(widx == V_WORDS[v], "R8", $sformatf("vec %0d words taken", v), widx, V_WORDS[v]);
      check(!unit_valid && !host_ready, "R9", "idle after end", {unit_valid, host_ready}, 0);
      check(addr_rd == exp_addr, "R2", "address unchanged by operation", addr_rd, exp_addr);
    end
    bp = 1'b0;

    // R10: zero count
    begin_op(0, 0);
    repeat (3) @(negedge clk);
    check(!host_ready && !unit_valid && widx == 0, "R10", "zero count idle",
          {host_ready, unit_valid, 8'(widx)}, 0);
    host_valid = 1'b0;

    // R10: restart in the middle of a mono operation
    write_addr(32'h0);
    begin_op(1, 32);
    for (int t = 0; t < 100 && ngot < 5; t++) @(negedge clk);
    write_addr(32'h1);
    begin_op(3, 3);
    wait_units(3);
    host_valid = 1'b0;
    check(ngot == 3, "R10", "restart unit count", ngot, 3);
    for (int k = 0; k < 3; k++)
      check(got[k] == ref_unit(3, 1, k), "R10", $sformatf("restart unit %0d", k),
            got[k], ref_unit(3, 1, k));
    check(widx == 1, "R10", "restart words taken", widx, 1);

    // R11: backpressure holds unit and blocks host
    write_addr(32'h0);
    hold = 1'b1;
    begin_op(0, 4);
    repeat (4) @(negedge clk);
    check(unit_valid && unit == gen(0)[7:0], "R11", "held unit", unit, gen(0)[7:0]);
    check(!host_ready && widx == 1, "R11", "host blocked while full", {host_ready, 8'(widx)}, 1);
    held = unit;
    repeat (3) @(negedge clk);
    check(unit == held && unit_valid, "R11", "unit stable", unit, held);
    hold = 1'b0;
    wait_units(4);
    host_valid = 1'b0;
    check(ngot == 4, "R11", "units after release", ngot, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule